// File: doc/BRIEF.md
# RMII Receive Frame Synchronizer

This block sits directly on the receive side of a reduced media-independent interface and runs on the 50 MHz reference clock. On every clock it samples the receive-enable line together with the two receive data bits and packs them into one 3-bit symbol. The symbols go into a short sliding history. The start of a frame is declared only when that history holds a full run of preamble dibits closed by the delimiter dibit.

Once synchronized, the block gathers every group of four following dibits into a byte. The first dibit of a group becomes the least significant bits of the byte. Each finished byte appears on the output with a one-clock strobe, and a frame-active flag stays high for the whole frame. When receive-enable is sampled low, the frame state is dropped and a one-clock end pulse is given. If the frame stopped partway through a byte, that byte is discarded and flagged.

A long match window is used instead of a check on the delimiter byte alone. Early dibits of a frame are the ones most likely to be corrupted by transmitter contention, so requiring the whole window lowers the chance of a false lock.

Top module: `rmii_frame_sync`

## Requirements
- R1: A synchronous active-high reset clears the symbol history and drives `in_frame_o`, `byte_stb_o`, `frame_end_o` and `align_err_o` low. Symbols sampled before reset cannot complete a match afterwards.
- R2: Each clock forms the symbol {rx_en_i, rx_pair_i[1], rx_pair_i[0]}, with receive-enable as the most significant bit. The history holds the newest PRE_SYMS+1 symbols. A symbol sampled with receive-enable low breaks any match that covers it.
- R3: `in_frame_o` rises in the cycle after the clock edge that samples a symbol 3'b111, provided the PRE_SYMS symbols before it were all 3'b101 (a preamble dibit 01 with enable high). With fewer preamble dibits, no sync occurs.
- R4: While a frame is active, the match is not tested. A preamble-and-delimiter pattern inside the frame data neither restarts the frame nor shifts byte alignment.
- R5: After sync, every four dibits form one byte on `byte_o`, with the first dibit in bits [1:0] and the last in bits [7:6]. `byte_stb_o` is high for exactly the one cycle after the edge that samples the fourth dibit.
- R6: When receive-enable is sampled low, `in_frame_o` is low in the next cycle.
- R7: When receive-enable is sampled low during an active frame, `frame_end_o` pulses high for one cycle in the next cycle.
- R8: If a frame ends with one to three dibits of an unfinished byte, that byte produces no strobe, and `align_err_o` pulses together with `frame_end_o`. A frame that ends on a byte boundary leaves `align_err_o` low.
- R9: When receive-enable is low and no frame was active, `frame_end_o` and `align_err_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en_i | input | 1 | Receive-enable line from the PHY |
| rx_pair_i | input | 2 | Receive data dibit |
| byte_o | output | 8 | Last assembled byte |
| byte_stb_o | output | 1 | One-cycle strobe for a new byte |
| in_frame_o | output | 1 | High while a synchronized frame is active |
| frame_end_o | output | 1 | One-cycle pulse when an active frame ends |
| align_err_o | output | 1 | One-cycle pulse when the frame ended inside a byte |

## Verification
The bench builds the block with the default PRE_SYMS of 7. This puts the sync threshold within reach: random preambles of 4 to 12 dibits fall on both sides of it, so frames with six preamble dibits must stay unsynchronized and frames with seven must lock. Random payloads and random trailing dibit counts of 0 to 3 cover every byte-alignment outcome at end of frame. Directed cases cover a delimiter pattern inside the payload, an enable dropout within the preamble, and a partial preamble cut by reset.

// File: rtl/rmii_frame_sync.sv
module rmii_frame_sync #(
  parameter int PRE_SYMS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en_i,
  input  logic [1:0] rx_pair_i,
  output logic [7:0] byte_o,
  output logic       byte_stb_o,
  output logic       in_frame_o,
  output logic       frame_end_o,
  output logic       align_err_o
);
  localparam int WIN = PRE_SYMS + 1;
  localparam int HW  = 3 * WIN;
  localparam logic [HW-1:0] MATCH = {3'b111, {PRE_SYMS{3'b101}}};

  logic [HW-4:0] hist;
  logic [HW-1:0] hist_nxt;
  logic          sync;
  logic [1:0]    cnt;
  logic [5:0]    part;
  logic          sof;

  assign hist_nxt   = {rx_en_i, rx_pair_i, hist};
  assign sof        = (hist_nxt == MATCH) && !sync && (cnt == 2'd0);
  assign in_frame_o = sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist        <= '0;
      sync        <= 1'b0;
      cnt         <= 2'd0;
      part        <= '0;
      byte_o      <= '0;
      byte_stb_o  <= 1'b0;
      frame_end_o <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      hist        <= hist_nxt[HW-1:3];
      byte_stb_o  <= 1'b0;
      frame_end_o <= 1'b0;
      align_err_o <= 1'b0;
      if (!rx_en_i) begin
        sync        <= 1'b0;
        cnt         <= 2'd0;
        frame_end_o <= sync;
        align_err_o <= sync && (cnt != 2'd0);
      end else if (sof) begin
        sync <= 1'b1;
        cnt  <= 2'd0;
      end else if (sync) begin
        cnt  <= cnt + 2'd1;
        part <= {rx_pair_i, part[5:2]};
        if (cnt == 2'd3) begin
          byte_o     <= {rx_pair_i, part};
          byte_stb_o <= 1'b1;
        end
      end
    end
  end

  // R5: a strobe only comes inside a frame and never twice in a row
  p_stb_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    byte_stb_o |-> in_frame_o);
  p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
    byte_stb_o |=> !byte_stb_o);
  // R3: sync only follows an enabled sample
  p_sync_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame_o) |-> $past(rx_en_i));
  // R6
  p_drop_on_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !rx_en_i |=> !in_frame_o);
  // R7
  p_end_after_frame_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |-> (!in_frame_o && $past(in_frame_o)));
  // R8
  p_err_with_end_r8: assert property (@(posedge clk) disable iff (rst)
    align_err_o |-> frame_end_o);
endmodule

// File: tb/rmii_frame_sync_tb.sv
module rmii_frame_sync_tb;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic [1:0] rx_pair = 2'b00;
  logic [7:0] byte_o;
  logic       byte_stb_o, in_frame_o, frame_end_o, align_err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmii_frame_sync u_dut (
    .clk(clk), .rst(rst), .rx_en_i(rx_en), .rx_pair_i(rx_pair),
    .byte_o(byte_o), .byte_stb_o(byte_stb_o), .in_frame_o(in_frame_o),
    .frame_end_o(frame_end_o), .align_err_o(align_err_o));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic [1:0] pr);
    rx_en = en;
    rx_pair = pr;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] dibit_of(input logic [7:0] b, input int k);
    return b[2*k +: 2];
  endfunction

  function automatic bit expect_sync(input int n_pre);
    return n_pre >= 7;
  endfunction

  // Sends one frame and checks it against the expected outcome.
  task automatic send_frame(input int n_pre, input logic [7:0] data[], input int extra);
    bit synced = expect_sync(n_pre);
    int seen = 0;
    for (int i = 0; i < n_pre; i++) tick(1'b1, 2'b01);
    tick(1'b1, 2'b11);
    check(synced ? "R3 sync after full window" : "R3 no sync on short preamble",
          in_frame_o, synced);
    foreach (data[j]) begin
      for (int k = 0; k < 4; k++) begin
        tick(1'b1, dibit_of(data[j], k));
        check("R5 strobe timing", byte_stb_o, synced && (k == 3));
        if (byte_stb_o) begin
          seen++;
          check("R5 byte value", byte_o, data[j]);
        end
        check("R4 frame held", in_frame_o, synced);
      end
    end
    for (int k = 0; k < extra; k++) begin
      tick(1'b1, 2'(k + 1));
      check("R8 no strobe for partial byte", byte_stb_o, 0);
    end
    check("R5 byte count", seen, synced ? data.size() : 0);
    tick(1'b0, 2'b00);
    check("R6 frame dropped", in_frame_o, 0);
    check(synced ? "R7 end pulse" : "R9 no end pulse", frame_end_o, synced);
    check("R8 align error", align_err_o, synced && extra != 0);
    tick(1'b0, 2'b00);
    check("R7 end pulse is one cycle", frame_end_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d[];
    void'($urandom(32'd4242));
    // R1: reset state
    tick(1'b0, 2'b00);
    tick(1'b0, 2'b00);
    check("R1 in_frame at reset", in_frame_o, 0);
    check("R1 byte_stb at reset", byte_stb_o, 0);
    check("R1 frame_end at reset", frame_end_o, 0);
    check("R1 align_err at reset", align_err_o, 0);
    // R1: a partial preamble cut by reset must not complete afterwards
    rst = 1'b0;
    for (int i = 0; i < 6; i++) tick(1'b1, 2'b01);
    rst = 1'b1;
    tick(1'b1, 2'b01);
    rst = 1'b0;
    tick(1'b1, 2'b01);
    tick(1'b1, 2'b11);
    check("R1 history cleared by reset", in_frame_o, 0);
    tick(1'b0, 2'b00);
    check("R9 no end without frame", frame_end_o, 0);
    tick(1'b0, 2'b00);

    // R2: enable dropout inside the preamble breaks the window
    for (int i = 0; i < 4; i++) tick(1'b1, 2'b01);
    tick(1'b0, 2'b01);
    for (int i = 0; i < 4; i++) tick(1'b1, 2'b01);
    tick(1'b1, 2'b11);
    check("R2 enable gap breaks match", in_frame_o, 0);
    tick(1'b0, 2'b00);
    tick(1'b0, 2'b00);

    // R3 boundary: 6 and 7 preamble dibits
    d = new[1]; d[0] = 8'hA7;
    send_frame(7, d, 0);
    d[0] = 8'h00;
    send_frame(6, d, 0);

    // R4: a preamble plus delimiter pattern inside the payload
    d = new[5]; d[0] = 8'h55; d[1] = 8'h55; d[2] = 8'hD5; d[3] = 8'h3C; d[4] = 8'h81;
    send_frame(31, d, 0);
    // R8: every trailing partial length
    d = new[2]; d[0] = 8'h12; d[1] = 8'hEF;
    for (int e = 1; e < 4; e++) send_frame(8, d, e);

    // Random frames
    for (int f = 0; f < 60; f++) begin
      int n_pre = 4 + int'($urandom_range(8));
      int nb = int'($urandom_range(6));
      int ex = int'($urandom_range(3));
      d = new[nb];
      foreach (d[j]) d[j] = expect_sync(n_pre) ? 8'($urandom) : 8'h00;
      if (!expect_sync(n_pre)) ex = 0;
      send_frame(n_pre, d, ex);
      for (int g = 0; g < int'($urandom_range(4)); g++) tick(1'b0, 2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule